// File: doc/BRIEF.md
# Multi-Latency Pipeline Hazard Interlock

This block is the stall and bypass controller for an in-order pipeline with fetch, decode, execute, memory and write-back steps. Execution is split across three units: an integer unit taking one cycle, a floating-point adder taking `FADD_LAT` cycles and a floating-point multiplier taking `FMUL_LAT` cycles. Each cycle the decoder presents the instruction in decode: its unit, its destination and its two source operands, each tagged integer or floating point. The block tracks every issued instruction through latency shift registers that model the units and the single memory step. From them it decides whether decode may issue this cycle, which bypass path feeds each operand, and whether a taken branch redirects fetch.

An operand is ready when its youngest in-flight producer is in the last cycle of its unit, or is in the memory step. A load's value exists only after memory. The memory step takes one instruction per cycle, so every issue reserves its arrival slot ahead of time. An instruction that would land on a reserved slot waits in decode. While decode waits, fetch is held too and a bubble is issued. Branches resolve in decode. The instruction already in fetch is kept, acting as a delay slot.

Top module: `hz_interlock`

## Requirements
- R1: After reset, with no valid instruction in decode, both stall outputs and the redirect are 0 and both bypass selects read 0 (register file).
- R2: A source that names the destination of a load still in its execute cycle stalls decode for one cycle; in the next cycle the source selects code 1 (memory step) and decode issues.
- R3: A source written by an integer (unit code 0) producer now in its execute cycle causes no stall and selects code 2. One cycle later the same producer is selected as code 1. Two cycles later code 0 is selected.
- R4: When several in-flight instructions write the same register, the most recently issued one decides both readiness and the bypass select.
- R5: A source produced by a multiply (unit code 2) stalls decode while the producer is in its first `FMUL_LAT-1` cycles. It issues with select code 4 when the producer is in its last cycle.
- R6: A source produced by an add (unit code 1) stalls decode while the producer is in its first `FADD_LAT-1` cycles. It issues with select code 3 when the producer is in its last cycle.
- R7: A register match counts only when the register class bit (1 = floating point) of source and destination agree.
- R8: An instruction whose memory-step arrival (issue cycle + unit latency + 1) equals that of an already issued instruction stalls in decode until the slot is free.
- R9: The fetch stall output equals the decode stall output in every cycle.
- R10: A branch (integer unit) with its condition true raises the redirect in its decode cycle only if it issues in that cycle. An untaken branch, or one stalled in decode, leaves the redirect at 0.
- R11: A scalar multiply-add loop body of eight instructions issues in 13 cycles, stalling in its 4th, 6th, 7th, 8th and 10th decode cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid_i | input | 1 | Decode holds a valid instruction |
| id_unit_i | input | 2 | Unit: 0 integer, 1 add, 2 multiply |
| id_load_i | input | 1 | Instruction is a load |
| id_branch_i | input | 1 | Instruction is a branch |
| id_br_cond_i | input | 1 | Branch condition is true |
| id_dst_we_i | input | 1 | Instruction writes a register |
| id_dst_fp_i | input | 1 | Destination class (1 = floating point) |
| id_dst_i | input | REG_W | Destination register number |
| id_sa_use_i | input | 1 | Source A is read |
| id_sa_fp_i | input | 1 | Source A class |
| id_sa_i | input | REG_W | Source A register number |
| id_sb_use_i | input | 1 | Source B is read |
| id_sb_fp_i | input | 1 | Source B class |
| id_sb_i | input | REG_W | Source B register number |
| stall_if_o | output | 1 | Hold the fetch register |
| stall_id_o | output | 1 | Hold decode and issue a bubble |
| fwd_a_o | output | 3 | Source A bypass: 0 file, 1 memory, 2 integer, 3 add, 4 multiply |
| fwd_b_o | output | 3 | Source B bypass, same coding |
| redirect_o | output | 1 | Load the branch target into the PC |

## Verification
Short directed programs are fed through a model of fetch and decode that holds while stalled. The logged stall pattern, the bypass selects and the redirect are compared against schedules worked out by hand. Back-to-back integer dependences tell the execute, memory and register-file paths apart. A register written twice shows that age picks the producer. Load, add and multiply dependences separate the three readiness windows. Pairs of independent instructions with colliding memory arrivals isolate the structural stall from data stalls. A class-mismatched pair shows that no false hazard is raised. The full loop body checks how all these interact, including a case where an older, already ready multiply result must lose to a younger add that is still busy.

// File: rtl/hzi_pkg.sv
package hzi_pkg;
  localparam int REG_W = 5;
  localparam int AGE_W = 4;

  typedef enum logic [1:0] {
    U_INT  = 2'd0,
    U_FADD = 2'd1,
    U_FMUL = 2'd2
  } unit_e;

  typedef enum logic [2:0] {
    FW_RF   = 3'd0,
    FW_MEM  = 3'd1,
    FW_INT  = 3'd2,
    FW_FADD = 3'd3,
    FW_FMUL = 3'd4
  } fwd_e;

  typedef struct packed {
    logic             vld;
    logic             we;
    logic             fp;
    logic [REG_W-1:0] dst;
    logic             ld;
    logic [AGE_W-1:0] age;
  } slot_t;
endpackage

// File: rtl/hzi_pipe.sv
module hzi_pipe
  import hzi_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  slot_t             ins_i,
  output slot_t [DEPTH-1:0] stg_o
);
  slot_t [DEPTH-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q[0] <= ins_i;
      for (int i = 1; i < DEPTH; i++) begin
        q[i]     <= q[i-1];
        q[i].age <= q[i-1].age + 1'b1;
      end
    end
  end

  assign stg_o = q;

  for (genvar s = 1; s < DEPTH; s++) begin : g_chk
    // R5 R6: an occupied stage was filled from the stage ahead of it
    p_stage_step_r5: assert property (@(posedge clk) disable iff (rst)
      q[s].vld |-> $past(q[s-1].vld));
  end
endmodule

// File: rtl/hzi_mbook.sv
module hzi_mbook #(
  parameter int SPAN = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take_i,
  input  logic [SPAN-1:0] req_i,
  output logic            busy_o,
  output logic [SPAN-1:0] book_o
);
  logic [SPAN-1:0] book_q;

  always_ff @(posedge clk) begin
    if (rst) book_q <= '0;
    else     book_q <= (book_q | (take_i ? req_i : '0)) >> 1;
  end

  assign busy_o = |(book_q & req_i);
  assign book_o = book_q;

  // R8: a granted issue never lands on a slot already reserved
  p_no_double_book_r8: assert property (@(posedge clk) disable iff (rst)
    take_i |-> !busy_o);
endmodule

// File: rtl/hzi_srcchk.sv
module hzi_srcchk
  import hzi_pkg::*;
#(
  parameter int NC = 8
) (
  input  logic                    use_i,
  input  logic                    fp_i,
  input  logic [REG_W-1:0]        reg_i,
  input  slot_t [NC-1:0]          cand_i,
  input  logic  [NC-1:0]          fin_i,
  input  logic  [NC-1:0]          mem_i,
  input  logic  [NC-1:0][2:0]     code_i,
  output logic                    hold_o,
  output logic [2:0]              fwd_o
);
  localparam int IW = (NC > 1) ? $clog2(NC) : 1;

  logic [IW-1:0]    best;
  logic [AGE_W-1:0] best_age;
  logic             hit;

  always_comb begin
    best     = '0;
    best_age = '1;
    hit      = 1'b0;
    for (int i = 0; i < NC; i++) begin
      if (cand_i[i].vld && cand_i[i].we && cand_i[i].fp == fp_i &&
          cand_i[i].dst == reg_i && cand_i[i].age < best_age) begin
        best     = IW'(i);
        best_age = cand_i[i].age;
        hit      = 1'b1;
      end
    end
  end

  always_comb begin
    hold_o = 1'b0;
    fwd_o  = FW_RF;
    if (use_i && hit) begin
      if (mem_i[best]) begin
        fwd_o = FW_MEM;
      end else if (fin_i[best] && !cand_i[best].ld) begin
        fwd_o = code_i[best];
      end else begin
        hold_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
  import hzi_pkg::*;
#(
  parameter int FADD_LAT = 2,
  parameter int FMUL_LAT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             id_valid_i,
  input  logic [1:0]       id_unit_i,
  input  logic             id_load_i,
  input  logic             id_branch_i,
  input  logic             id_br_cond_i,
  input  logic             id_dst_we_i,
  input  logic             id_dst_fp_i,
  input  logic [REG_W-1:0] id_dst_i,
  input  logic             id_sa_use_i,
  input  logic             id_sa_fp_i,
  input  logic [REG_W-1:0] id_sa_i,
  input  logic             id_sb_use_i,
  input  logic             id_sb_fp_i,
  input  logic [REG_W-1:0] id_sb_i,
  output logic             stall_if_o,
  output logic             stall_id_o,
  output logic [2:0]       fwd_a_o,
  output logic [2:0]       fwd_b_o,
  output logic             redirect_o
);
  localparam int MAXLAT = (FMUL_LAT > FADD_LAT) ? FMUL_LAT : FADD_LAT;
  localparam int SPAN   = MAXLAT + 2;
  localparam int LW     = $clog2(SPAN + 1);
  localparam int NC     = 1 + FADD_LAT + FMUL_LAT + 1;
  localparam int I_ADD  = FADD_LAT;
  localparam int I_MUL  = FADD_LAT + FMUL_LAT;
  localparam int I_MEM  = NC - 1;

  unit_e                unit;
  logic                 stall, issue, busy;
  logic [LW-1:0]        lat;
  logic [SPAN-1:0]      req, book;
  slot_t                new_slot, int_in, add_in, mul_in, mem_d, mem_q;
  slot_t [0:0]          int_s;
  slot_t [FADD_LAT-1:0] add_s;
  slot_t [FMUL_LAT-1:0] mul_s;
  slot_t [NC-1:0]       cands;
  logic  [NC-1:0]       is_fin, is_mem;
  logic  [NC-1:0][2:0]  codes;
  logic  [1:0]          s_use, s_fp, hold;
  logic  [1:0][REG_W-1:0] s_reg;
  logic  [1:0][2:0]     fwd;

  assign unit = unit_e'(id_unit_i);

  always_comb begin
    case (unit)
      U_FADD:  lat = LW'(FADD_LAT);
      U_FMUL:  lat = LW'(FMUL_LAT);
      default: lat = LW'(1);
    endcase
    req = SPAN'(1) << (lat + 1'b1);
  end

  always_comb begin
    new_slot     = '0;
    new_slot.vld = 1'b1;
    new_slot.we  = id_dst_we_i;
    new_slot.fp  = id_dst_fp_i;
    new_slot.dst = id_dst_i;
    new_slot.ld  = id_load_i;
    new_slot.age = AGE_W'(1);
    int_in = (issue && unit != U_FADD && unit != U_FMUL) ? new_slot : '0;
    add_in = (issue && unit == U_FADD) ? new_slot : '0;
    mul_in = (issue && unit == U_FMUL) ? new_slot : '0;
  end

  hzi_pipe #(.DEPTH(1))        u_int (.clk(clk), .rst(rst), .ins_i(int_in), .stg_o(int_s));
  hzi_pipe #(.DEPTH(FADD_LAT)) u_add (.clk(clk), .rst(rst), .ins_i(add_in), .stg_o(add_s));
  hzi_pipe #(.DEPTH(FMUL_LAT)) u_mul (.clk(clk), .rst(rst), .ins_i(mul_in), .stg_o(mul_s));

  hzi_mbook #(.SPAN(SPAN)) u_book (
    .clk(clk), .rst(rst), .take_i(issue), .req_i(req), .busy_o(busy), .book_o(book)
  );

  always_comb begin
    if (int_s[0].vld)               mem_d = int_s[0];
    else if (add_s[FADD_LAT-1].vld) mem_d = add_s[FADD_LAT-1];
    else if (mul_s[FMUL_LAT-1].vld) mem_d = mul_s[FMUL_LAT-1];
    else                            mem_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_q <= '0;
    end else begin
      mem_q     <= mem_d;
      mem_q.age <= mem_d.age + 1'b1;
    end
  end

  assign cands = {mem_q, mul_s, add_s, int_s};

  always_comb begin
    is_fin = '0;
    is_mem = '0;
    codes  = '0;
    is_fin[0]     = 1'b1; codes[0]     = FW_INT;
    is_fin[I_ADD] = 1'b1; codes[I_ADD] = FW_FADD;
    is_fin[I_MUL] = 1'b1; codes[I_MUL] = FW_FMUL;
    is_mem[I_MEM] = 1'b1;
  end

  assign s_use = {id_sb_use_i, id_sa_use_i};
  assign s_fp  = {id_sb_fp_i, id_sa_fp_i};
  assign s_reg = {id_sb_i, id_sa_i};

  for (genvar g = 0; g < 2; g++) begin : g_src
    hzi_srcchk #(.NC(NC)) u_chk (
      .use_i(s_use[g]), .fp_i(s_fp[g]), .reg_i(s_reg[g]),
      .cand_i(cands), .fin_i(is_fin), .mem_i(is_mem), .code_i(codes),
      .hold_o(hold[g]), .fwd_o(fwd[g])
    );
  end

  assign stall      = id_valid_i && (hold[0] || hold[1] || busy);
  assign issue      = id_valid_i && !stall;
  assign stall_id_o = stall;
  assign stall_if_o = stall;
  assign fwd_a_o    = fwd[0];
  assign fwd_b_o    = fwd[1];
  assign redirect_o = issue && id_branch_i && id_br_cond_i;

  // R8: the three units never hand over to the memory step together
  p_single_mem_r8: assert property (@(posedge clk) disable iff (rst)
    $countones({int_s[0].vld, add_s[FADD_LAT-1].vld, mul_s[FMUL_LAT-1].vld}) <= 1);

  // R8: a slot reserved for the next cycle is filled in that cycle
  p_book_fill_r8: assert property (@(posedge clk) disable iff (rst)
    book[1] |=> mem_q.vld);

  // R9: a stalled decode cycle sends a bubble into every unit
  p_bubble_r9: assert property (@(posedge clk) disable iff (rst)
    stall_id_o |=> !(int_s[0].vld || add_s[0].vld || mul_s[0].vld));

  // R10: a redirecting branch enters the integer unit
  p_redirect_issue_r10: assert property (@(posedge clk) disable iff (rst)
    redirect_o |=> int_s[0].vld);

  // R4: the memory step always holds an older instruction than any first stage
  p_mem_age_r4: assert property (@(posedge clk) disable iff (rst)
    mem_q.vld |-> mem_q.age >= AGE_W'(2));
endmodule

// File: tb/hz_interlock_tb_top.sv
module hz_interlock_tb_top;
  localparam int RW = 5;
  localparam logic [2:0] C_RF = 3'd0, C_MEM = 3'd1, C_INT = 3'd2, C_ADD = 3'd3, C_MUL = 3'd4;

  typedef struct packed {
    logic [1:0]    unit;
    logic          ld, br, cnd, we, dfp;
    logic [RW-1:0] d;
    logic          ua, afp;
    logic [RW-1:0] a;
    logic          ub, bfp;
    logic [RW-1:0] b;
  } ins_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic id_valid, id_load, id_branch, id_br_cond, id_dst_we, id_dst_fp;
  logic id_sa_use, id_sa_fp, id_sb_use, id_sb_fp;
  logic [1:0] id_unit;
  logic [RW-1:0] id_dst, id_sa, id_sb;
  logic stall_if, stall_id, redirect;
  logic [2:0] fwd_a, fwd_b;

  int checks = 0;
  int failures = 0;
  ins_t prog [16];
  logic       st_log [64];
  logic       rd_log [64];
  logic [2:0] fa_log [64];
  logic [2:0] fb_log [64];
  bit if_mismatch;

  always #4 clk = ~clk;

  hz_interlock dut_i (
    .clk(clk), .rst(rst), .id_valid_i(id_valid), .id_unit_i(id_unit),
    .id_load_i(id_load), .id_branch_i(id_branch), .id_br_cond_i(id_br_cond),
    .id_dst_we_i(id_dst_we), .id_dst_fp_i(id_dst_fp), .id_dst_i(id_dst),
    .id_sa_use_i(id_sa_use), .id_sa_fp_i(id_sa_fp), .id_sa_i(id_sa),
    .id_sb_use_i(id_sb_use), .id_sb_fp_i(id_sb_fp), .id_sb_i(id_sb),
    .stall_if_o(stall_if), .stall_id_o(stall_id), .fwd_a_o(fwd_a),
    .fwd_b_o(fwd_b), .redirect_o(redirect)
  );

  function automatic ins_t mk(input logic [1:0] u, input logic ld, input logic br,
      input logic cnd, input logic we, input logic dfp, input int d,
      input logic ua, input logic afp, input int a,
      input logic ub, input logic bfp, input int b);
    ins_t x;
    x.unit = u; x.ld = ld; x.br = br; x.cnd = cnd; x.we = we; x.dfp = dfp;
    x.d = RW'(d); x.ua = ua; x.afp = afp; x.a = RW'(a);
    x.ub = ub; x.bfp = bfp; x.b = RW'(b);
    return x;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    id_valid = 1'b0; id_unit = 2'd0; id_load = 1'b0; id_branch = 1'b0;
    id_br_cond = 1'b0; id_dst_we = 1'b0; id_dst_fp = 1'b0; id_dst = '0;
    id_sa_use = 1'b0; id_sa_fp = 1'b0; id_sa = '0;
    id_sb_use = 1'b0; id_sb_fp = 1'b0; id_sb = '0;
  endtask

  task automatic drive(input ins_t x);
    id_valid = 1'b1; id_unit = x.unit; id_load = x.ld; id_branch = x.br;
    id_br_cond = x.cnd; id_dst_we = x.we; id_dst_fp = x.dfp; id_dst = x.d;
    id_sa_use = x.ua; id_sa_fp = x.afp; id_sa = x.a;
    id_sb_use = x.ub; id_sb_fp = x.bfp; id_sb = x.b;
  endtask

  // Runs prog[0..n-1] through a fetch/decode model that holds on stall
  task automatic run(input int n, output int cycles, output int mask);
    int pc = 0;
    int cyc = 0;
    mask = 0;
    if_mismatch = 1'b0;
    while (pc < n && cyc < 60) begin
      @(negedge clk);
      drive(prog[pc]);
      #1;
      st_log[cyc] = stall_id;
      rd_log[cyc] = redirect;
      fa_log[cyc] = fwd_a;
      fb_log[cyc] = fwd_b;
      if (stall_if !== stall_id) if_mismatch = 1'b1;
      if (stall_id && cyc < 31) mask = mask | (1 << cyc);
      if (!stall_id) pc++;
      cyc++;
    end
    cycles = cyc;
    @(negedge clk);
    idle();
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk(stall_id == 1'b0, "R1 stall_id", stall_id, 0);
    chk(stall_if == 1'b0, "R1 stall_if", stall_if, 0);
    chk(redirect == 1'b0, "R1 redirect", redirect, 0);
    chk(fwd_a == C_RF && fwd_b == C_RF, "R1 fwd", {fwd_a, fwd_b}, 0);
  endtask

  task automatic t_int_paths();
    int c, m;
    prog[0] = mk(0,0,0,0,1,0,1, 0,0,0, 0,0,0);
    prog[1] = mk(0,0,0,0,1,0,2, 1,0,1, 0,0,0);
    prog[2] = mk(0,0,0,0,1,0,3, 1,0,1, 0,0,0);
    prog[3] = mk(0,0,0,0,1,0,4, 1,0,1, 0,0,0);
    run(4, c, m);
    chk(m == 0, "R3 no stall", m, 0);
    chk(fa_log[1] == C_INT, "R3 exec path", fa_log[1], C_INT);
    chk(fa_log[2] == C_MEM, "R3 mem path", fa_log[2], C_MEM);
    chk(fa_log[3] == C_RF, "R3 file path", fa_log[3], C_RF);
    chk(!if_mismatch, "R9 fetch stall", if_mismatch, 0);
  endtask

  task automatic t_youngest();
    int c, m;
    prog[0] = mk(0,0,0,0,1,0,1, 0,0,0, 0,0,0);
    prog[1] = mk(0,0,0,0,1,0,1, 0,0,0, 0,0,0);
    prog[2] = mk(0,0,0,0,1,0,6, 0,0,0, 1,0,1);
    run(3, c, m);
    chk(fb_log[2] == C_INT, "R4 youngest writer", fb_log[2], C_INT);
    chk(m == 0, "R4 no stall", m, 0);
  endtask

  task automatic t_load_use();
    int c, m;
    prog[0] = mk(0,1,0,0,1,0,4, 1,0,9, 0,0,0);
    prog[1] = mk(0,0,0,0,1,0,5, 1,0,4, 0,0,0);
    run(2, c, m);
    chk(m == 2, "R2 load-use stall", m, 2);
    chk(fa_log[2] == C_MEM, "R2 mem bypass", fa_log[2], C_MEM);
    chk(!if_mismatch, "R9 fetch stall", if_mismatch, 0);
  endtask

  task automatic t_class();
    int c, m;
    prog[0] = mk(0,1,0,0,1,0,4, 0,0,0, 0,0,0);
    prog[1] = mk(1,0,0,0,1,1,7, 1,1,4, 0,0,0);
    run(2, c, m);
    chk(m == 0 && c == 2, "R7 class mismatch", m, 0);
    chk(fa_log[1] == C_RF, "R7 file select", fa_log[1], C_RF);
  endtask

  task automatic t_mul_raw();
    int c, m;
    prog[0] = mk(2,0,0,0,1,1,1, 1,1,2, 1,1,3);
    prog[1] = mk(1,0,0,0,1,1,5, 1,1,1, 0,0,0);
    run(2, c, m);
    chk(m == 14, "R5 mul hold", m, 14);
    chk(fa_log[4] == C_MUL, "R5 mul bypass", fa_log[4], C_MUL);
    chk(!if_mismatch, "R9 fetch stall", if_mismatch, 0);
  endtask

  task automatic t_struct();
    int c, m;
    prog[0] = mk(1,0,0,0,1,1,2, 0,0,0, 0,0,0);
    prog[1] = mk(0,0,0,0,0,0,0, 1,0,5, 1,1,6);
    run(2, c, m);
    chk(m == 2, "R8 add vs int", m, 2);
    prog[0] = mk(2,0,0,0,1,1,2, 0,0,0, 0,0,0);
    prog[1] = mk(0,0,0,0,1,0,10, 0,0,0, 0,0,0);
    prog[2] = mk(0,0,0,0,1,0,11, 0,0,0, 0,0,0);
    prog[3] = mk(0,0,0,0,1,0,12, 0,0,0, 0,0,0);
    run(4, c, m);
    chk(m == 8, "R8 mul vs int", m, 8);
  endtask

  task automatic t_branch();
    int c, m;
    prog[0] = mk(0,0,1,0,0,0,0, 1,0,3, 0,0,0);
    run(1, c, m);
    chk(rd_log[0] == 1'b0, "R10 untaken", rd_log[0], 0);
    prog[0] = mk(0,1,0,0,1,0,5, 0,0,0, 0,0,0);
    prog[1] = mk(0,0,1,1,0,0,0, 1,0,5, 0,0,0);
    run(2, c, m);
    chk(st_log[1] == 1'b1 && rd_log[1] == 1'b0, "R10 stalled branch", rd_log[1], 0);
    chk(rd_log[2] == 1'b1, "R10 taken", rd_log[2], 1);
  endtask

  task automatic t_loop();
    int c, m;
    prog[0] = mk(0,1,0,0,1,1,3, 1,0,1, 0,0,0);
    prog[1] = mk(0,1,0,0,1,1,4, 1,0,1, 0,0,0);
    prog[2] = mk(0,1,0,0,1,1,2, 1,0,0, 0,0,0);
    prog[3] = mk(2,0,0,0,1,1,1, 1,1,2, 1,1,3);
    prog[4] = mk(1,0,0,0,1,1,1, 1,1,1, 1,1,4);
    prog[5] = mk(0,0,0,0,0,0,0, 1,0,0, 1,1,1);
    prog[6] = mk(0,0,0,0,1,0,0, 1,0,0, 0,0,0);
    prog[7] = mk(0,0,1,1,0,0,0, 1,0,0, 0,0,0);
    run(8, c, m);
    chk(c == 13, "R11 loop cycles", c, 13);
    chk(m == 744, "R11 stall pattern", m, 744);
    chk(fa_log[4] == C_MEM, "R2 load into mul", fa_log[4], C_MEM);
    chk(fa_log[8] == C_MUL, "R5 mul into add", fa_log[8], C_MUL);
    chk(st_log[9] == 1'b1, "R4 younger add wins", st_log[9], 1);
    chk(fb_log[10] == C_ADD, "R6 add bypass", fb_log[10], C_ADD);
    chk(fa_log[12] == C_INT && rd_log[12] == 1'b1, "R10 loop branch", rd_log[12], 1);
    chk(!if_mismatch, "R9 fetch stall", if_mismatch, 0);
  endtask

  initial begin
    #(8 * 20000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_int_paths();
    t_youngest();
    t_load_use();
    t_class();
    t_mul_raw();
    t_struct();
    t_branch();
    t_loop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule